// File: doc/BRIEF.md
# Video Self-Test Go/No-Go Checker

This block decides whether an internally generated test picture came through the receive datapath intact. It watches the recovered video words together with line-check and field-boundary markers. Each line or field carries a check word, and the block computes its own check code over the same words and compares the two. High-definition streams use two cyclic codes per line, one for the luma channel and one for the chroma channel. Standard-definition streams use one checksum per field, computed over the multiplexed words on the luma channel.

A run starts when the test enable goes high. Fields are counted only from the first field boundary after that, so a partial field is never counted. If the required number of whole fields (two by default) pass without a mismatch, the pass bit rises. Any mismatch, or a test source that cannot serve as a self-test pattern, latches an internal error that keeps the pass bit low until the enable is dropped and raised again. The pass bit is held for a register read and can also be switched onto a general-purpose output pin in place of that pin's normal function.

Top module: `video_bist_chk`

## Requirements
- R1: After reset, `pass` is 0 and the internal error latch and field counter are clear.
- R2: In HD mode, luma and chroma each run a separate 18-bit CRC with polynomial x^18+x^5+x^4+1. The CRC starts at 0 and takes each 10-bit word least significant bit first (feedback = MSB xor data bit, shift left, xor 0x00031 when feedback is set). At a `chk_stb` cycle the two codes are compared with `chk_luma` and `chk_chroma`, and a difference in either one counts as an error.
- R3: In SD mode, a 16-bit CRC with polynomial x^16+x^12+x^5+1 (0x1021, same bit order, start 0) runs over the luma words of a field and is compared with `chk_luma[15:0]` at `chk_stb`. The chroma input, `chk_chroma` and `chk_luma[17:16]` have no effect.
- R4: The first `field_bnd` after enable starts the count. `pass` becomes 1 in the cycle after the boundary that closes the second whole field (the third boundary seen), provided no error was latched.
- R5: A mismatch found after the first boundary latches the error. From the next cycle `pass` is 0, even if it was already 1, and it stays 0 until the enable is raised again.
- R6: Check mismatches that arrive after enable but before the first field boundary are ignored.
- R7: `pat_kind` codes are 0 black, 1 PLL pathological, 2 equaliser pathological and 3 colour bars. `lines_625` = 1 selects the 625-line standard. A run can pass only with colour bars in HD, or in SD with colour bars at 525 lines or the PLL pathological at 625 lines. Any other source keeps `pass` at 0.
- R8: A rising edge of `test_en` clears `pass` and the error latch in the next cycle and re-arms the field count.
- R9: While `test_en` is 0, `pass` holds its value, and boundaries and check strobes have no effect on it.
- R10: `gpo` equals `pass` when `gpo_sel` is 1, and equals `gpo_alt` otherwise.
- R11: Check-code accumulators restart from 0 at every `field_bnd` and after every `chk_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Self-test enable; a rising edge starts a run |
| hd_mode | input | 1 | 1 = HD line CRCs, 0 = SD field checksum |
| pat_kind | input | 2 | Test source kind (see R7) |
| lines_625 | input | 1 | 1 = 625-line standard, 0 = 525-line |
| word_vld | input | 1 | Luma/chroma words valid this cycle |
| luma | input | 10 | Luma channel word |
| chroma | input | 10 | Chroma channel word |
| field_bnd | input | 1 | Field boundary marker, one cycle |
| chk_stb | input | 1 | Received check words valid this cycle |
| chk_luma | input | 18 | Received luma check word |
| chk_chroma | input | 18 | Received chroma check word |
| gpo_sel | input | 1 | Route pass bit to the general-purpose output |
| gpo_alt | input | 1 | Normal function for the general-purpose output |
| pass | output | 1 | Sticky self-test pass status |
| gpo | output | 1 | General-purpose output |

## Verification
The assertions assume that `field_bnd`, `chk_stb` and `word_vld` never share a cycle. A strobe or boundary cycle carries no data, so the accumulator clearing rule and the mismatch timing are both well defined. The stimulus tasks always issue a boundary, then data words, then a strobe, each in its own cycle, with data lines separated by their strobes. Outside strobe cycles the check inputs are filled with random values, so any read of them outside a strobe would show up as a mismatch.

// File: rtl/vbist_pkg.sv
package vbist_pkg;

    localparam int PIX_W_DEF = 10;
    localparam int HD_W_DEF  = 18;
    localparam int SD_W_DEF  = 16;

    localparam logic [HD_W_DEF-1:0] HD_POLY = 18'h00031;
    localparam logic [SD_W_DEF-1:0] SD_POLY = 16'h1021;

    typedef enum logic [1:0] {
        PAT_BLACK = 2'd0,
        PAT_PLL   = 2'd1,
        PAT_EQ    = 2'd2,
        PAT_BARS  = 2'd3
    } pat_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } run_state_e;

    typedef struct packed {
        logic en;
        logic rise;
        logic bnd;
        logic bad;
        logic src_ok;
    } seq_evt_t;

    function automatic logic source_ok(input logic hd, input pat_kind_e k,
                                       input logic l625);
        if (hd)
            return k == PAT_BARS;
        return (k == PAT_BARS && !l625) || (k == PAT_PLL && l625);
    endfunction

endpackage

// File: rtl/vbist_crc.sv
module vbist_crc #(
    parameter int DW = 10,
    parameter int CW = 18,
    parameter logic [CW-1:0] POLY = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          upd,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] crc
);

    function automatic logic [CW-1:0] step(input logic [CW-1:0] c,
                                           input logic [DW-1:0] d);
        logic [CW-1:0] r;
        logic          fb;
        r = c;
        for (int i = 0; i < DW; i++) begin
            fb = r[CW-1] ^ d[i];
            r  = {r[CW-2:0], 1'b0};
            if (fb)
                r = r ^ POLY;
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= '0;
        else if (upd)
            crc <= step(crc, din);
    end

    // R11: accumulator restarts after a boundary or strobe
    a_r11_clear_restart: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc == '0));

    // R11: idle cycles leave the code untouched
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!clr && !upd) |=> $stable(crc));

endmodule

// File: rtl/vbist_cmp.sv
module vbist_cmp #(
    parameter int HW = 18,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hd,
    input  logic          stb,
    input  logic [HW-1:0] hd_y,
    input  logic [HW-1:0] hd_c,
    input  logic [SW-1:0] sd_y,
    input  logic [HW-1:0] chk_y,
    input  logic [HW-1:0] chk_c,
    output logic          bad
);

    logic hd_bad;
    logic sd_bad;

    always_comb begin
        hd_bad = (hd_y != chk_y) || (hd_c != chk_c);
        sd_bad = sd_y != chk_y[SW-1:0];
        bad    = stb && (hd ? hd_bad : sd_bad);
    end

    // R2/R3: a mismatch can only be raised by a strobe cycle
    a_r2_bad_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        !stb |-> !bad);

endmodule

// File: rtl/vbist_seq.sv
module vbist_seq
    import vbist_pkg::*;
#(
    parameter int FIELDS = 2,
    localparam int CNT_W = (FIELDS < 2) ? 1 : $clog2(FIELDS)
) (
    input  logic     clk,
    input  logic     rst,
    input  seq_evt_t ev,
    output logic     pass
);

    run_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             err_q, err_n;
    logic             pass_q, pass_n;
    logic             counting;

    assign counting = (st_q == ST_COUNT) || (st_q == ST_DONE);

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        err_n  = err_q;
        pass_n = pass_q;
        if (ev.rise) begin
            st_n   = ST_ARM;
            cnt_n  = '0;
            err_n  = 1'b0;
            pass_n = 1'b0;
        end else if (!ev.en) begin
            st_n = ST_IDLE;
        end else begin
            if (!ev.src_ok || (ev.bad && counting)) begin
                err_n  = 1'b1;
                pass_n = 1'b0;
            end
            if (ev.bnd) begin
                unique case (st_q)
                    ST_ARM: begin
                        st_n  = ST_COUNT;
                        cnt_n = '0;
                    end
                    ST_COUNT: begin
                        if (cnt_q == CNT_W'(FIELDS - 1)) begin
                            st_n   = ST_DONE;
                            pass_n = !err_n;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            err_q  <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            err_q  <= err_n;
            pass_q <= pass_n;
        end
    end

    assign pass = pass_q;

    // R4: pass can only rise right after a field boundary
    a_r4_rise_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(pass_q) |-> $past(ev.bnd));

    // R5: a latched error excludes pass
    a_r5_err_blocks_pass: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !pass_q);

    // R5: the error latch is only released by a new enable edge
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_q && !ev.rise) |=> err_q);

    // R7: unusable source never lets pass through
    a_r7_bad_source: assert property (@(posedge clk) disable iff (rst)
        (ev.en && !ev.src_ok) |=> !pass_q);

    // R8: enable edge clears pass
    a_r8_rise_clears: assert property (@(posedge clk) disable iff (rst)
        ev.rise |=> (!pass_q && !err_q));

    // R9: disabled checker holds pass
    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        !ev.en |=> $stable(pass_q));

endmodule

// File: rtl/video_bist_chk.sv
module video_bist_chk
    import vbist_pkg::*;
#(
    parameter int PIX_W  = PIX_W_DEF,
    parameter int HD_W   = HD_W_DEF,
    parameter int SD_W   = SD_W_DEF,
    parameter int FIELDS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_en,
    input  logic             hd_mode,
    input  logic [1:0]       pat_kind,
    input  logic             lines_625,
    input  logic             word_vld,
    input  logic [PIX_W-1:0] luma,
    input  logic [PIX_W-1:0] chroma,
    input  logic             field_bnd,
    input  logic             chk_stb,
    input  logic [HD_W-1:0]  chk_luma,
    input  logic [HD_W-1:0]  chk_chroma,
    input  logic             gpo_sel,
    input  logic             gpo_alt,
    output logic             pass,
    output logic             gpo
);

    localparam int LANES = 2;

    logic [PIX_W-1:0] lane_din [LANES];
    logic [HD_W-1:0]  lane_crc [LANES];
    logic [SD_W-1:0]  sd_crc;
    logic             acc_clr;
    logic             mism;
    logic             en_q;
    seq_evt_t         ev;

    assign acc_clr     = field_bnd || chk_stb;
    assign lane_din[0] = luma;
    assign lane_din[1] = chroma;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_hd_lane
            vbist_crc #(.DW(PIX_W), .CW(HD_W), .POLY(HD_W'(HD_POLY))) u_crc (
                .clk (clk),
                .rst (rst),
                .clr (acc_clr),
                .upd (word_vld),
                .din (lane_din[g]),
                .crc (lane_crc[g])
            );
        end
    endgenerate

    vbist_crc #(.DW(PIX_W), .CW(SD_W), .POLY(SD_W'(SD_POLY))) u_sd_crc (
        .clk (clk),
        .rst (rst),
        .clr (acc_clr),
        .upd (word_vld),
        .din (luma),
        .crc (sd_crc)
    );

    vbist_cmp #(.HW(HD_W), .SW(SD_W)) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .hd    (hd_mode),
        .stb   (chk_stb),
        .hd_y  (lane_crc[0]),
        .hd_c  (lane_crc[1]),
        .sd_y  (sd_crc),
        .chk_y (chk_luma),
        .chk_c (chk_chroma),
        .bad   (mism)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= test_en;
    end

    always_comb begin
        ev.en     = test_en;
        ev.rise   = test_en && !en_q;
        ev.bnd    = field_bnd;
        ev.bad    = mism;
        ev.src_ok = source_ok(hd_mode, pat_kind_e'(pat_kind), lines_625);
    end

    vbist_seq #(.FIELDS(FIELDS)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .pass (pass)
    );

    assign gpo = gpo_sel ? pass : gpo_alt;

    // R1: pass is low the cycle after reset
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !pass);

    // R10: deselected output follows its normal function
    a_r10_alt_route: assert property (@(posedge clk) disable iff (rst)
        !gpo_sel |-> (gpo == gpo_alt));

endmodule

// File: tb/video_bist_chk_test.sv
`timescale 1ns/1ps
module video_bist_chk_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        test_en = 1'b0;
    logic        hd_mode = 1'b1;
    logic [1:0]  pat_kind = 2'd3;
    logic        lines_625 = 1'b0;
    logic        word_vld = 1'b0;
    logic [9:0]  luma = '0;
    logic [9:0]  chroma = '0;
    logic        field_bnd = 1'b0;
    logic        chk_stb = 1'b0;
    logic [17:0] chk_luma = '0;
    logic [17:0] chk_chroma = '0;
    logic        gpo_sel = 1'b1;
    logic        gpo_alt = 1'b0;
    logic        pass;
    logic        gpo;

    int    checks = 0;
    int    fails = 0;
    bit    cmp_on = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_pass, m_err, m_st, m_cnt, m_enq, ay, ac, as;

    always #2.5 clk = ~clk;

    video_bist_chk uut (
        .clk(clk), .rst(rst), .test_en(test_en), .hd_mode(hd_mode),
        .pat_kind(pat_kind), .lines_625(lines_625), .word_vld(word_vld),
        .luma(luma), .chroma(chroma), .field_bnd(field_bnd),
        .chk_stb(chk_stb), .chk_luma(chk_luma), .chk_chroma(chk_chroma),
        .gpo_sel(gpo_sel), .gpo_alt(gpo_alt), .pass(pass), .gpo(gpo)
    );

    function automatic int crc_f(int c, int d, int w, int poly);
        int r = c;
        for (int i = 0; i < 10; i++) begin
            int fb = ((r >> (w - 1)) ^ (d >> i)) & 1;
            r = (r << 1) & ((1 << w) - 1);
            if (fb != 0) r = r ^ poly;
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model: states 0 idle, 1 armed, 2 counting, 3 done
    always @(posedge clk) begin
        int rise, bad, ok;
        if (rst) begin
            m_pass = 0; m_err = 0; m_st = 0; m_cnt = 0; m_enq = 0;
            ay = 0; ac = 0; as = 0;
        end else begin
            rise = (test_en && m_enq == 0) ? 1 : 0;
            if (!chk_stb) bad = 0;
            else if (hd_mode) bad = (int'(chk_luma) != ay || int'(chk_chroma) != ac) ? 1 : 0;
            else bad = ((int'(chk_luma) & 'hFFFF) != as) ? 1 : 0;
            if (hd_mode) ok = (pat_kind == 3) ? 1 : 0;
            else ok = ((pat_kind == 3 && !lines_625) || (pat_kind == 1 && lines_625)) ? 1 : 0;
            if (rise != 0) begin
                m_st = 1; m_cnt = 0; m_err = 0; m_pass = 0;
            end else if (!test_en) begin
                m_st = 0;
            end else begin
                if (ok == 0 || (bad != 0 && m_st >= 2)) begin
                    m_err = 1; m_pass = 0;
                end
                if (field_bnd) begin
                    if (m_st == 1) begin
                        m_st = 2; m_cnt = 0;
                    end else if (m_st == 2) begin
                        m_cnt++;
                        if (m_cnt == 2) begin
                            m_st = 3;
                            m_pass = (m_err == 0) ? 1 : 0;
                        end
                    end
                end
            end
            if (field_bnd || chk_stb) begin
                ay = 0; ac = 0; as = 0;
            end else if (word_vld) begin
                ay = crc_f(ay, int'(luma), 18, 'h31);
                ac = crc_f(ac, int'(chroma), 18, 'h31);
                as = crc_f(as, int'(luma), 16, 'h1021);
            end
            m_enq = test_en ? 1 : 0;
        end
    end

    // cycle-by-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(int'(pass) == m_pass, cur_req, int'(pass), m_pass);
            chk(gpo == (gpo_sel ? (m_pass != 0) : gpo_alt), "R10", int'(gpo),
                gpo_sel ? m_pass : int'(gpo_alt));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic bnd();
        field_bnd = 1'b1;
        cyc();
        field_bnd = 1'b0;
    endtask

    // lines of words, each HD line closed by its strobe; SD strobe at field end
    task automatic body(bit hd, int lines, bit bad_y, bit bad_c, int bad_line);
        int sy = 0;
        for (int l = 0; l < lines; l++) begin
            int hy = 0;
            int hc = 0;
            for (int w = 0; w < 6; w++) begin
                luma   = 10'($urandom_range(0, 1023));
                chroma = 10'($urandom_range(0, 1023));
                word_vld = 1'b1;
                hy = crc_f(hy, int'(luma), 18, 'h31);
                hc = crc_f(hc, int'(chroma), 18, 'h31);
                sy = crc_f(sy, int'(luma), 16, 'h1021);
                chk_luma   = 18'($urandom);
                chk_chroma = 18'($urandom);
                cyc();
            end
            word_vld = 1'b0;
            if (hd) begin
                chk_stb    = 1'b1;
                chk_luma   = 18'(hy ^ ((bad_y && l == bad_line) ? 1 : 0));
                chk_chroma = 18'(hc ^ ((bad_c && l == bad_line) ? 1 : 0));
                cyc();
                chk_stb = 1'b0;
            end
        end
        if (!hd) begin
            chk_stb    = 1'b1;
            chk_luma   = {2'($urandom), 16'(sy ^ (bad_y ? 1 : 0))};
            chk_chroma = 18'($urandom);
            cyc();
            chk_stb = 1'b0;
        end
    endtask

    task automatic field(bit hd, bit bad_y, bit bad_c);
        bnd();
        body(hd, 3, bad_y, bad_c, 1);
    endtask

    task automatic restart();
        test_en = 1'b0;
        cyc();
        test_en = 1'b1;
        cyc();
        chk(pass == 1'b0, "R8", int'(pass), 0);
    endtask

    task automatic full_run(bit hd, bit bad_y, bit bad_c, int exp, string req);
        restart();
        body(hd, 2, 1'b1, 1'b1, 0);
        field(hd, 1'b0, 1'b0);
        field(hd, bad_y, bad_c);
        chk(pass == 1'b0, "R4", int'(pass), 0);
        bnd();
        idle(2);
        chk(int'(pass) == exp, req, int'(pass), exp);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        cmp_on = 1'b1;
        #1.5;
        chk(pass == 1'b0, "R1", int'(pass), 0);
        chk(gpo == 1'b0, "R1", int'(gpo), 0);
        #1;

        // HD clean run; early bad lines before the first boundary (R6)
        cur_req = "R4";
        hd_mode = 1'b1; pat_kind = 2'd3; lines_625 = 1'b0;
        full_run(1'b1, 1'b0, 1'b0, 1, "R6");

        // HD luma error, then more clean fields keep pass low
        cur_req = "R2";
        full_run(1'b1, 1'b1, 1'b0, 0, "R2");
        cur_req = "R5";
        field(1'b1, 1'b0, 1'b0);
        bnd();
        idle(2);
        chk(pass == 1'b0, "R5", int'(pass), 0);

        // HD chroma error
        cur_req = "R2";
        full_run(1'b1, 1'b0, 1'b1, 0, "R2");

        // SD 625-line PLL pathological: chroma and upper check bits random
        cur_req = "R3";
        hd_mode = 1'b0; pat_kind = 2'd1; lines_625 = 1'b1;
        full_run(1'b0, 1'b0, 1'b0, 1, "R3");
        full_run(1'b0, 1'b1, 1'b0, 0, "R3");

        // SD 525-line colour bars pass, then an error after pass (R5)
        cur_req = "R7";
        pat_kind = 2'd3; lines_625 = 1'b0;
        full_run(1'b0, 1'b0, 1'b0, 1, "R7");
        cur_req = "R5";
        field(1'b0, 1'b1, 1'b0);
        idle(1);
        chk(pass == 1'b0, "R5", int'(pass), 0);

        // unusable sources
        cur_req = "R7";
        pat_kind = 2'd2;
        full_run(1'b0, 1'b0, 1'b0, 0, "R7");
        pat_kind = 2'd3; lines_625 = 1'b1;
        full_run(1'b0, 1'b0, 1'b0, 0, "R7");
        hd_mode = 1'b1; pat_kind = 2'd1;
        full_run(1'b1, 1'b0, 1'b0, 0, "R7");

        // disabled checker holds pass through errors and boundaries
        cur_req = "R9";
        pat_kind = 2'd3; lines_625 = 1'b0;
        full_run(1'b1, 1'b0, 1'b0, 1, "R9");
        test_en = 1'b0;
        field(1'b1, 1'b1, 1'b1);
        bnd();
        bnd();
        idle(2);
        chk(pass == 1'b1, "R9", int'(pass), 1);

        // enable edge clears a held pass
        cur_req = "R8";
        test_en = 1'b1;
        cyc();
        chk(pass == 1'b0, "R8", int'(pass), 0);

        // output routing
        cur_req = "R10";
        full_run(1'b1, 1'b0, 1'b0, 1, "R10");
        gpo_sel = 1'b0;
        for (int i = 0; i < 4; i++) begin
            gpo_alt = i[0];
            cyc();
            chk(gpo == i[0], "R10", int'(gpo), int'(i[0]));
        end
        gpo_sel = 1'b1;
        idle(2);
        chk(gpo == 1'b1, "R10", int'(gpo), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule